// File: doc/BRIEF.md
# Four-Bit Eight-Function Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for 4-bit operands. A 3-bit function code picks one of four bitwise logic functions or one of four arithmetic functions. The block returns a 4-bit result and a carry-out. No clock or storage is involved: a change on any input reaches the outputs within the same evaluation.

The four arithmetic functions share one ripple-carry adder, built from per-bit full-adder slices. The carry passes from bit 0 up to the top bit. Each slice steers the adder's second operand with a four-way multiplexer, choosing between the B bit, its inverse, constant 0 and constant 1. A second four-way multiplexer forms the logic value, and a two-way multiplexer picks between the logic value and the adder sum. A small decoder turns the function code into the operand choice and the carry-in for the chain.

Top module: `alu4_core`

## Requirements
- R1: With the function code's top bit at 0, the result is the bitwise logic function picked by the low two bits: 000 gives A AND B, 001 gives A XOR B, 010 gives A XNOR B, and 011 gives A OR B.
- R2: For every logic function code (000 to 011), the carry-out is 0 whatever the operands.
- R3: Code 100 adds A and B with a carry-in of 0. The result is (A+B) mod 16, and the carry-out is 1 exactly when A+B is 16 or more.
- R4: Code 101 subtracts by adding the inverse of B with a carry-in of 1. The result is (A−B) mod 16, and the carry-out is 1 exactly when A is greater than or equal to B.
- R5: Code 110 increments A by adding zero with a carry-in of 1, ignoring B. The result is (A+1) mod 16, and the carry-out is 1 exactly when A is 15.
- R6: Code 111 decrements A by adding all ones with a carry-in of 0, ignoring B. The result is (A−1) mod 16, and the carry-out is 1 exactly when A is not 0.
- R7: The outputs are combinational. A new A, B or function code is reflected on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand (not used by increment and decrement) |
| op_i | input | 3 | Function code |
| res_o | output | 4 | Result |
| cout_o | output | 1 | Carry-out of the adder chain; 0 for logic functions |

## Verification
Two effects can arise from the same input change: the result wrapping modulo 16, and the carry-out rising, because both come from the last slice of the chain. The bench sweeps every operand pair under every function code, so each wrap point is crossed. These include A+B reaching 16, A below B in subtraction, A at 15 for increment and A at 0 for decrement. At each point the 4-bit result and the carry-out are compared together against values computed arithmetically. The same operands are also applied under the logic codes, which shows that the carry-out is forced low while the chain below may still produce a carry.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_XOR  = 3'b001,
        OP_XNOR = 3'b010,
        OP_OR   = 3'b011,
        OP_ADD  = 3'b100,
        OP_SUB  = 3'b101,
        OP_INC  = 3'b110,
        OP_DEC  = 3'b111
    } alu_op_e;

    // second adder operand choice; encoding matches the low function bits
    typedef enum logic [1:0] {
        OPND_PASS = 2'b00,
        OPND_INV  = 2'b01,
        OPND_ZERO = 2'b10,
        OPND_ONES = 2'b11
    } opnd_e;

    typedef struct packed {
        logic       arith;
        logic [1:0] lsel;
        opnd_e      opnd;
        logic       cin;
    } alu_ctl_t;

    // four-way selector: 00 -> d, 01 -> b, 10 -> c, 11 -> a
    function automatic logic mux4(input logic [1:0] s, input logic in_a,
                                  input logic in_b, input logic in_c,
                                  input logic in_d);
        logic y;
        case (s)
            2'b00:   y = in_d;
            2'b01:   y = in_b;
            2'b10:   y = in_c;
            default: y = in_a;
        endcase
        return y;
    endfunction

    // returns {carry, sum}
    function automatic logic [1:0] full_add(input logic x, input logic y,
                                            input logic ci);
        logic s;
        logic co;
        s  = x ^ y ^ ci;
        co = (x & y) | (x & ci) | (y & ci);
        return {co, s};
    endfunction

endpackage

// File: rtl/alu4_opdec.sv
module alu4_opdec
    import alu4_pkg::*;
(
    input  logic [2:0] op_i,
    output alu_ctl_t   ctl_o
);
    opnd_e sel;

    always_comb begin
        sel             = opnd_e'(op_i[1:0]);
        ctl_o.arith     = op_i[2];
        ctl_o.lsel      = op_i[1:0];
        ctl_o.opnd      = sel;
        // subtract and increment inject a carry into bit 0
        ctl_o.cin       = op_i[2] & ((sel == OPND_INV) | (sel == OPND_ZERO));
    end
endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
    import alu4_pkg::*;
(
    input  logic     a_bit,
    input  logic     b_bit,
    input  alu_ctl_t ctl,
    input  logic     c_in,
    output logic     r_bit,
    output logic     c_out
);
    logic       lg_val;
    logic       opnd_bit;
    logic [1:0] fa_out;

    always_comb begin
        // logic slots: a=OR, b=XOR, c=XNOR, d=AND
        lg_val   = mux4(ctl.lsel, a_bit | b_bit, a_bit ^ b_bit,
                        ~(a_bit ^ b_bit), a_bit & b_bit);
        // operand slots: a=ones, b=inverse, c=zero, d=pass
        opnd_bit = mux4(ctl.opnd, 1'b1, ~b_bit, 1'b0, b_bit);
        fa_out   = full_add(a_bit, opnd_bit, c_in);
        c_out    = fa_out[1];
        r_bit    = ctl.arith ? fa_out[0] : lg_val;
    end
endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam int CHAIN = WIDTH + 1;

    alu_ctl_t         ctl;
    logic [CHAIN-1:0] chain;

    alu4_opdec u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    assign chain[0] = ctl.cin;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_slice
            alu4_slice u_bit (
                .a_bit (a_i[i]),
                .b_bit (b_i[i]),
                .ctl   (ctl),
                .c_in  (chain[i]),
                .r_bit (res_o[i]),
                .c_out (chain[i+1])
            );
        end
    endgenerate

    assign cout_o = ctl.arith & chain[WIDTH];
endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] res_o,
    input logic             cout_o
);
    localparam logic [WIDTH:0] ONE = {{WIDTH{1'b0}}, 1'b1};

    logic [WIDTH:0] ax;
    logic [WIDTH:0] bx;

    always_comb begin
        ax = {1'b0, a_i};
        bx = {1'b0, b_i};
        if (!op_i[2]) begin
            assert_logic_nocarry_R2: assert (cout_o == 1'b0);
        end
        if (op_i == 3'b000) begin
            assert_and_R1: assert (res_o == (a_i & b_i));
        end
        if (op_i == 3'b011) begin
            assert_or_R1: assert (res_o == (a_i | b_i));
        end
        if (op_i == 3'b100) begin
            assert_add_R3: assert ({cout_o, res_o} == ax + bx);
        end
        if (op_i == 3'b101) begin
            assert_sub_R4: assert (res_o == a_i - b_i && cout_o == (a_i >= b_i));
        end
        if (op_i == 3'b110) begin
            assert_inc_R5: assert ({cout_o, res_o} == ax + ONE);
        end
        if (op_i == 3'b111) begin
            assert_dec_R6: assert (res_o == a_i - 1'b1 && cout_o == (a_i != '0));
        end
    end
endmodule

bind alu4_core alu4_core_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .op_i   (op_i),
    .res_o  (res_o),
    .cout_o (cout_o)
);

// File: tb/alu4_core_test.sv
`timescale 1ns/1ps
module alu4_core_test;
    logic       clk;
    logic       rst;
    logic [3:0] a;
    logic [3:0] b;
    logic [2:0] op;
    logic [3:0] res;
    logic       cout;
    int         n_checks;
    int         n_fail;
    bit         done;

    alu4_core #(.WIDTH(4)) uut (
        .a_i    (a),
        .b_i    (b),
        .op_i   (op),
        .res_o  (res),
        .cout_o (cout)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input logic [3:0] exp_r,
                         input logic exp_c);
        n_checks++;
        if (res !== exp_r || cout !== exp_c) begin
            n_fail++;
            $display("FAIL %s op=%b a=%0d b=%0d actual res=%0d cout=%b expected res=%0d cout=%b",
                     req, op, a, b, res, cout, exp_r, exp_c);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        n_checks = 0;
        n_fail   = 0;
        done     = 1'b0;
        rst      = 1'b1;
        a        = '0;
        b        = '0;
        op       = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // quiescent inputs: AND of zeros
        check("R1 idle", 4'd0, 1'b0);

        // R7: inputs change between edges, outputs read 1 ns later
        for (int o = 0; o < 8; o++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    int       ev;
                    logic [3:0] er;
                    logic       ec;
                    string      tag;
                    a  = 4'(x);
                    b  = 4'(y);
                    op = 3'(o);
                    #1;
                    ec = 1'b0;
                    case (o)
                        0: begin er = 4'(x & y);    tag = "R1 and R2 R7"; end
                        1: begin er = 4'(x ^ y);    tag = "R1 xor R2 R7"; end
                        2: begin er = ~4'(x ^ y);   tag = "R1 xnor R2 R7"; end
                        3: begin er = 4'(x | y);    tag = "R1 or R2 R7"; end
                        4: begin ev = x + y;  er = 4'(ev % 16);
                                 ec = (ev >= 16);   tag = "R3 add R7"; end
                        5: begin ev = x - y + 16; er = 4'(ev % 16);
                                 ec = (x >= y);     tag = "R4 sub R7"; end
                        6: begin ev = x + 1;  er = 4'(ev % 16);
                                 ec = (x == 15);    tag = "R5 inc R7"; end
                        default: begin ev = x + 15; er = 4'(ev % 16);
                                 ec = (x != 0);     tag = "R6 dec R7"; end
                    endcase
                    check(tag, er, ec);
                    @(negedge clk);
                end
            end
        end
        done = 1'b1;
        finish_run();
    end
endmodule